// File: doc/BRIEF.md
# Interrupt Pending Qualification Register

This block brings a set of asynchronous interrupt inputs into the system clock domain and holds one pending indication for each source, ready for per-processor selectors further down the chip. Each external source is configured on its own: it can latch an event on an edge, or follow a level, and either polarity can be treated as active. Internal sources, such as inter-processor and timer interrupts, keep a separate pending bit for each destination processor. Each of those bits is gated by that processor's destination enable.

A per-source mask acts only on the outgoing request. A latched event is therefore never lost while its source is masked, and it is requested as soon as the mask drops. A single acknowledge strobe, carrying a source index and a processor index, clears latched bits. Level-followed sources ignore the acknowledge and drop only when their input goes inactive. All configuration arrives as plain inputs.

Top module: `irq_pend_qual`

## Requirements
- R1: During and right after a synchronous reset, every request output is 0.
- R2: An external source with sense bit 0 (edge mode) and polarity bit 1 latches a rising input edge. Its request stays 1 after the input falls, until it is acknowledged.
- R3: An external edge-mode source with polarity bit 0 latches a falling edge and ignores a rising edge.
- R4: An external source with sense bit 1 (level mode) requests while its synchronized input equals its polarity bit, so polarity 1 means active high and polarity 0 means active low. An acknowledge to it has no effect.
- R5: When a mask bit is 1, the matching requests are 0 one edge later. An event that arrives while masked is still latched, and its request appears one edge after the mask returns to 0.
- R6: An acknowledge with index i below N_EXT clears only the edge-mode pending bit of external source i. An index equal to or above N_EXT+N_INT has no effect.
- R7: If an acknowledge and a new latched edge hit the same bit in the same cycle, the bit stays set.
- R8: A rising edge on internal event i sets pending bit i*N_CPU+c of int_req_o for every processor c whose destination bit i*N_CPU+c is 1. Processors whose destination bit is 0 get no pending bit.
- R9: An acknowledge with index N_EXT+i and processor index c clears only internal pending bit i*N_CPU+c.
- R10: An input change reaches the request outputs after four clock edges for edge-latched sources and after three for level-followed sources: two synchronizer stages, one pending stage for edge sources, and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_i | input | N_EXT | Asynchronous external interrupt inputs |
| ext_sense_i | input | N_EXT | 0 = edge latched, 1 = level followed |
| ext_pol_i | input | N_EXT | 1 = high/rising active, 0 = low/falling active |
| ext_mask_i | input | N_EXT | 1 = hold the external request low |
| int_evt_i | input | N_INT | Internal event inputs, rising edge active |
| int_dest_i | input | N_INT*N_CPU | Destination enable, bit i*N_CPU+c |
| int_mask_i | input | N_INT | 1 = hold all requests of internal source i low |
| ack_valid_i | input | 1 | Acknowledge strobe, one cycle |
| ack_src_i | input | SRCW | Source index: externals first, then internals |
| ack_cpu_i | input | CPUW | Processor index, used for internal sources |
| ext_req_o | output | N_EXT | Qualified external requests |
| int_req_o | output | N_INT*N_CPU | Qualified internal requests, bit i*N_CPU+c |

## Verification
The bench uses the default sizes: four external sources, two internal sources and two processors. With these sizes the 3-bit acknowledge index covers both index ranges and also has two codes, 6 and 7, that match no source, so the ignored-index case can be reached. Two processors per internal source are enough to show that an acknowledge clears one processor's bit and leaves its neighbour set, and that a destination bit of 0 blocks capture. Four external lanes let one level-mode vector mix polarities and masks across lanes.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  // width of an index field able to address n items (at least one bit)
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_sync.sv
// Two-stage synchronizer followed by a history stage for edge detection.
module irq_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stage1_q, stage2_q, hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
      hist_q   <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
      hist_q   <= stage2_q;
    end
  end

  assign cur_o  = stage2_q;
  assign prev_o = hist_q;
endmodule

// File: rtl/ext_pend_cell.sv
// One external source: edge latch or level follow, polarity, output mask.
module ext_pend_cell (
  input  logic clk,
  input  logic rst,
  input  logic cur_i,
  input  logic prev_i,
  input  logic sense_i,
  input  logic pol_i,
  input  logic mask_i,
  input  logic ack_hit_i,
  output logic req_o
);
  logic active_lvl, edge_evt, pend_q, req_q;

  assign active_lvl = ~(cur_i ^ pol_i);
  assign edge_evt   = ~sense_i & (pol_i ? (cur_i & ~prev_i) : (~cur_i & prev_i));

  always_ff @(posedge clk) begin
    if (rst)            pend_q <= 1'b0;
    else if (sense_i)   pend_q <= 1'b0;
    else if (edge_evt)  pend_q <= 1'b1;
    else if (ack_hit_i) pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= ~mask_i & (sense_i ? active_lvl : pend_q);
  end

  assign req_o = req_q;

  assert_edge_capture_R2: assert property (@(posedge clk) disable iff (rst)
    edge_evt |=> pend_q);
  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (!sense_i && ack_hit_i && !edge_evt) |=> !pend_q);
  assert_ack_loses_R7: assert property (@(posedge clk) disable iff (rst)
    (edge_evt && ack_hit_i) |=> pend_q);
  assert_level_follow_R4: assert property (@(posedge clk) disable iff (rst)
    (sense_i && !mask_i) |=> (req_q == $past(active_lvl)));
  assert_mask_gate_R5: assert property (@(posedge clk) disable iff (rst)
    mask_i |=> !req_q);
endmodule

// File: rtl/int_pend_cell.sv
// One internal source: rising edge sets one pending bit per enabled processor.
module int_pend_cell #(
  parameter int N_CPU = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cur_i,
  input  logic             prev_i,
  input  logic [N_CPU-1:0] dest_i,
  input  logic             mask_i,
  input  logic [N_CPU-1:0] ack_hit_i,
  output logic [N_CPU-1:0] req_o
);
  logic             rise;
  logic [N_CPU-1:0] set_vec, pend_q, req_q;

  assign rise    = cur_i & ~prev_i;
  assign set_vec = {N_CPU{rise}} & dest_i;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= set_vec | (pend_q & ~ack_hit_i);
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= mask_i ? '0 : pend_q;
  end

  assign req_o = req_q;

  for (genvar c = 0; c < N_CPU; c++) begin : g_chk
    assert_int_set_R8: assert property (@(posedge clk) disable iff (rst)
      (rise && dest_i[c]) |=> pend_q[c]);
    assert_int_nodest_R8: assert property (@(posedge clk) disable iff (rst)
      (!pend_q[c] && !(rise && dest_i[c])) |=> !pend_q[c]);
    assert_int_ack_R9: assert property (@(posedge clk) disable iff (rst)
      (ack_hit_i[c] && !set_vec[c]) |=> !pend_q[c]);
    assert_int_keep_R9: assert property (@(posedge clk) disable iff (rst)
      (pend_q[c] && !ack_hit_i[c]) |=> pend_q[c]);
    assert_int_mask_R5: assert property (@(posedge clk) disable iff (rst)
      mask_i |=> !req_q[c]);
  end
endmodule

// File: rtl/irq_pend_qual.sv
module irq_pend_qual
  import irq_pend_pkg::*;
#(
  parameter int N_EXT = 4,
  parameter int N_INT = 2,
  parameter int N_CPU = 2,
  localparam int N_SRC = N_EXT + N_INT,
  localparam int SRCW  = idx_width(N_SRC),
  localparam int CPUW  = idx_width(N_CPU)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_EXT-1:0]       ext_irq_i,
  input  logic [N_EXT-1:0]       ext_sense_i,
  input  logic [N_EXT-1:0]       ext_pol_i,
  input  logic [N_EXT-1:0]       ext_mask_i,
  input  logic [N_INT-1:0]       int_evt_i,
  input  logic [N_INT*N_CPU-1:0] int_dest_i,
  input  logic [N_INT-1:0]       int_mask_i,
  input  logic                   ack_valid_i,
  input  logic [SRCW-1:0]        ack_src_i,
  input  logic [CPUW-1:0]        ack_cpu_i,
  output logic [N_EXT-1:0]       ext_req_o,
  output logic [N_INT*N_CPU-1:0] int_req_o
);
  logic [N_EXT-1:0] ext_cur, ext_prev;
  logic [N_INT-1:0] int_cur, int_prev;

  irq_sync #(.W(N_EXT)) u_ext_sync (
    .clk(clk), .rst(rst), .async_i(ext_irq_i), .cur_o(ext_cur), .prev_o(ext_prev));
  irq_sync #(.W(N_INT)) u_int_sync (
    .clk(clk), .rst(rst), .async_i(int_evt_i), .cur_o(int_cur), .prev_o(int_prev));

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    logic hit;
    assign hit = ack_valid_i && (ack_src_i == SRCW'(i));
    ext_pend_cell u_cell (
      .clk(clk), .rst(rst), .cur_i(ext_cur[i]), .prev_i(ext_prev[i]),
      .sense_i(ext_sense_i[i]), .pol_i(ext_pol_i[i]), .mask_i(ext_mask_i[i]),
      .ack_hit_i(hit), .req_o(ext_req_o[i]));
  end

  for (genvar i = 0; i < N_INT; i++) begin : g_int
    logic [N_CPU-1:0] hit;
    for (genvar c = 0; c < N_CPU; c++) begin : g_hit
      assign hit[c] = ack_valid_i && (ack_src_i == SRCW'(N_EXT + i))
                      && (ack_cpu_i == CPUW'(c));
    end
    int_pend_cell #(.N_CPU(N_CPU)) u_cell (
      .clk(clk), .rst(rst), .cur_i(int_cur[i]), .prev_i(int_prev[i]),
      .dest_i(int_dest_i[i*N_CPU +: N_CPU]), .mask_i(int_mask_i[i]),
      .ack_hit_i(hit), .req_o(int_req_o[i*N_CPU +: N_CPU]));
  end
endmodule

// File: tb/sim_irq_pend_qual.sv
`timescale 1ns/1ps
module sim_irq_pend_qual;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ext_irq = '0, ext_sense = '0, ext_pol = 4'hF, ext_mask = '0;
  logic [1:0] int_evt = '0, int_mask = '0;
  logic [3:0] int_dest = '0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_src = '0;
  logic       ack_cpu = 1'b0;
  logic [3:0] ext_req, int_req;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_pend_qual u0 (
    .clk(clk), .rst(rst), .ext_irq_i(ext_irq), .ext_sense_i(ext_sense),
    .ext_pol_i(ext_pol), .ext_mask_i(ext_mask), .int_evt_i(int_evt),
    .int_dest_i(int_dest), .int_mask_i(int_mask), .ack_valid_i(ack_valid),
    .ack_src_i(ack_src), .ack_cpu_i(ack_cpu), .ext_req_o(ext_req),
    .int_req_o(int_req));

  // level-mode vectors: [15:12] input, [11:8] polarity, [7:4] mask, [3:0] expected
  localparam logic [15:0] TBL [0:5] = '{16'hFF0F, 16'h0F00, 16'h000F,
                                        16'hAF38, 16'hAC09, 16'h664B};

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_ack(input int src, input int cpu);
    ack_valid = 1'b1; ack_src = 3'(src); ack_cpu = cpu[0];
    tick(1);
    ack_valid = 1'b0;
    tick(2);
  endtask

  initial begin
    tick(3);
    chk("R1 in reset", {ext_req | int_req}, 4'h0);
    rst = 1'b0;
    tick(1);
    chk("R1 after reset ext", ext_req, 4'h0);
    chk("R1 after reset int", int_req, 4'h0);

    // R10 / R2: edge latency and stickiness on sources 0 and 1
    ext_irq[1:0] = 2'b11;
    tick(3);
    chk("R10 edge not yet", ext_req, 4'h0);
    tick(1);
    chk("R10 edge at 4th edge", ext_req, 4'h3);
    ext_irq[1:0] = 2'b00;
    tick(5);
    chk("R2 held after input falls", ext_req, 4'h3);

    // R6: unused index ignored, then clear source 0 only
    do_ack(7, 0);
    chk("R6 unused index ignored", ext_req, 4'h3);
    do_ack(0, 0);
    chk("R6 ack clears source 0 only", ext_req, 4'h2);
    do_ack(1, 1);
    chk("R6 ack clears source 1", ext_req, 4'h0);

    // R3: falling-edge polarity on source 2
    ext_pol[2] = 1'b0;
    tick(2);
    ext_irq[2] = 1'b1;
    tick(5);
    chk("R3 rising ignored", ext_req, 4'h0);
    ext_irq[2] = 1'b0;
    tick(5);
    chk("R3 falling latched", ext_req, 4'h4);
    do_ack(2, 0);
    ext_pol[2] = 1'b1;
    tick(2);

    // R7: ack in same cycle as a fresh edge on source 3
    ext_irq[3] = 1'b1;
    tick(5);
    ext_irq[3] = 1'b0;
    tick(3);
    chk("R7 precondition pending", ext_req, 4'h8);
    ext_irq[3] = 1'b1;
    tick(2);
    ack_valid = 1'b1; ack_src = 3'd3;
    tick(1);
    ack_valid = 1'b0;
    tick(2);
    chk("R7 new edge wins over ack", ext_req, 4'h8);
    do_ack(3, 0);
    chk("R6 plain ack clears source 3", ext_req, 4'h0);
    ext_irq[3] = 1'b0;
    tick(3);

    // R5: event latched while masked
    ext_mask[0] = 1'b1;
    ext_irq[0] = 1'b1;
    tick(2);
    ext_irq[0] = 1'b0;
    tick(5);
    chk("R5 masked hides request", ext_req, 4'h0);
    ext_mask[0] = 1'b0;
    tick(1);
    chk("R5 appears after unmask", ext_req, 4'h1);
    ext_mask[0] = 1'b1;
    tick(1);
    chk("R5 mask forces zero", ext_req, 4'h0);
    ext_mask[0] = 1'b0;
    do_ack(0, 0);
    chk("R5 cleared after ack", ext_req, 4'h0);

    // R10 / R4: level latency and ack immunity on source 1
    ext_sense[1] = 1'b1;
    tick(3);
    ext_irq[1] = 1'b1;
    tick(2);
    chk("R10 level not yet", ext_req, 4'h0);
    tick(1);
    chk("R10 level at 3rd edge", ext_req, 4'h2);
    do_ack(1, 0);
    chk("R4 ack ignored on level", ext_req, 4'h2);
    ext_irq[1] = 1'b0;
    tick(3);
    chk("R4 drops with level", ext_req, 4'h0);

    // R4 / R5: level-mode vector table
    ext_sense = 4'hF;
    for (int k = 0; k < 6; k++) begin
      ext_irq  = TBL[k][15:12];
      ext_pol  = TBL[k][11:8];
      ext_mask = TBL[k][7:4];
      tick(4);
      chk($sformatf("R4 R5 level vector %0d", k), ext_req, TBL[k][3:0]);
    end

    // R8 / R9: internal sources, destinations int0 -> cpu0,cpu1; int1 -> cpu1
    int_dest = 4'b1011;
    int_evt = 2'b11;
    tick(5);
    chk("R8 internal capture by destination", int_req, 4'b1011);
    int_evt = 2'b00;
    do_ack(4, 1);
    chk("R9 clears int0 cpu1 only", int_req, 4'b1001);
    do_ack(5, 0);
    chk("R9 ack of empty bit no effect", int_req, 4'b1001);
    do_ack(5, 1);
    chk("R9 clears int1 cpu1", int_req, 4'b0001);
    do_ack(4, 0);
    chk("R9 clears int0 cpu0", int_req, 4'b0000);

    // R5 on internal source 1
    int_mask[1] = 1'b1;
    int_evt[1] = 1'b1;
    tick(5);
    chk("R5 internal masked", int_req, 4'b0000);
    int_mask[1] = 1'b0;
    tick(1);
    chk("R5 internal after unmask", int_req, 4'b1000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule